// File: doc/BRIEF.md
# Multiplexed Host Register Port

This block is the slave side of a narrow parallel link to a host microcontroller. Address and data take turns on one 8-bit bus. An address strobe and a data strobe mark them, and both are sampled on their falling edges. Bytes written by the host land in a small bank of configuration registers. The timing generators downstream read these registers directly from the block's outputs. Several position values are 9 bits wide. Each keeps its low byte at its own address. Their ninth bits are gathered into one collector register, which the host writes on its own.

The host reads back status through a one-shot turnaround. Writing the read command as an address arms the port. The next address/data cycle is then a read: its address picks a status byte, and the data strobe acts as an active-low read strobe while the port drives the bus. The status bytes are the 10-bit measured field length and a field identification bit, both supplied by neighbouring logic. The bus is split into an input half, an output half and an output enable, so the pad ring can build the bidirectional pin.

The strobes are asynchronous to the system clock. Each one passes through two flip-flops, and its edges are detected on the synchronised copies. The host must therefore hold each address or data byte on the bus for at least three clock periods after the matching strobe falls.

Top module: `hostbus_port`

## Requirements
- R1: While reset is asserted, and after it is released, every configuration register reads zero on the outputs and the output enable is low (input mode).
- R2: A falling edge of `ale` latches `bus_in` as the address. A later falling edge of `wrd` writes `bus_in` into the addressed register. Addresses 0x40 to 0x47 hold the low bytes of positions 0 to 7, and position i occupies bits [9i+7:9i] of `pos_flat`.
- R3: Address 0x48 is the MSB collector: its bit i becomes bit 9i+8 of `pos_flat`. Writing a low byte leaves the collected MSBs unchanged, and writing the collector leaves the low bytes unchanged.
- R4: Addresses 0x49 to 0x4C are plain configuration bytes 0 to 3, shown on `cfg_flat[8j+7:8j]`.
- R5: A data strobe whose address is not mapped (for example 0x20, 0x4D or 0x81) changes no output.
- R6: The address 0x80 arms read mode. The data strobe of that same cycle writes nothing. Only the one address/data cycle that follows is a read cycle.
- R7: In the read cycle, `bus_oe` is high only while the synchronised `wrd` is low. It falls when `wrd` rises again, and that rising edge ends read mode.
- R8: Read address 0x80 returns bit 0 = field length bit 8, bit 1 = field length bit 9, bit 2 = `fld_id`, and zero in bits 7:3. Read address 0x81 returns field length bits 7:0.
- R9: A read of any other address drives 0x00.
- R10: A data strobe during the read cycle writes nothing. After the read cycle ends, the next address/data cycle is an ordinary write, even if it uses 0x81.
- R11: If `wrd` falls just before clock edge k, the written value shows on the outputs after edge k+2 and not after edge k+1. The enable also rises only after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address strobe; its falling edge latches the address |
| wrd | input | 1 | Data strobe; its falling edge latches write data; active-low read strobe in the read cycle |
| bus_in | input | 8 | Bus value seen by the port |
| bus_out | output | 8 | Read data driven toward the bus |
| bus_oe | output | 1 | Output enable for the bus driver |
| fld_len | input | 10 | Measured field length |
| fld_id | input | 1 | Current field identification bit |
| pos_flat | output | 72 | Eight 9-bit positions, position i at [9i+8:9i] |
| cfg_flat | output | 32 | Four configuration bytes |

## Verification
The bench probes the one-shot turnaround from both sides. A port that stayed in read mode would drive the bus on the following cycle and drop a write to 0x81. A port that never armed would write the read command's data cycle or leave the bus undriven. It checks that the MSB collector and the low bytes are written independently: a decode that overlapped them would corrupt half of a 9-bit position. It also writes to unmapped addresses and reads an unmapped address, which would expose a decode that aliases addresses. It pins the strobe latency to an exact clock edge, so a missing or extra synchroniser stage fails the check.

// File: rtl/hostbus_port.sv
module hostbus_port #(
  parameter int NPOS = 8,
  parameter int NCFG = 4,
  parameter int LW = 10,
  parameter logic [7:0] POS_BASE = 8'h40,
  parameter logic [7:0] RD_CMD = 8'h80,
  parameter logic [7:0] LEN_LO = 8'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              wrd,
  input  logic [7:0]        bus_in,
  output logic [7:0]        bus_out,
  output logic              bus_oe,
  input  logic [LW-1:0]     fld_len,
  input  logic              fld_id,
  output logic [NPOS*9-1:0] pos_flat,
  output logic [NCFG*8-1:0] cfg_flat
);
  localparam logic [7:0] MSB_ADDR = POS_BASE + 8'(NPOS);
  localparam logic [7:0] CFG_BASE = MSB_ADDR + 8'd1;

  logic [2:0] ale_sh, wrd_sh;
  logic ale_fall, wrd_fall, wrd_rise;
  logic [7:0] addr_q;
  logic rd_arm, rd_win;
  logic [7:0] lo_q [NPOS];
  logic [NPOS-1:0] msb_q;
  logic [7:0] cfg_q [NCFG];
  logic [7:0] rd_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ale_sh <= '0;
      wrd_sh <= '1;
    end else begin
      ale_sh <= {ale_sh[1:0], ale};
      wrd_sh <= {wrd_sh[1:0], wrd};
    end

  assign ale_fall = ale_sh[2] & ~ale_sh[1];
  assign wrd_fall = wrd_sh[2] & ~wrd_sh[1];
  assign wrd_rise = ~wrd_sh[2] & wrd_sh[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q <= '0;
      rd_arm <= 1'b0;
      rd_win <= 1'b0;
    end else if (ale_fall) begin
      addr_q <= bus_in;
      if (rd_arm) begin
        rd_arm <= 1'b0;
        rd_win <= 1'b1;
      end else begin
        rd_arm <= (bus_in == RD_CMD);
        rd_win <= 1'b0;
      end
    end else if (rd_win && wrd_rise) begin
      rd_win <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      msb_q <= '0;
      for (int i = 0; i < NPOS; i++) lo_q[i] <= '0;
      for (int j = 0; j < NCFG; j++) cfg_q[j] <= '0;
    end else if (wrd_fall && !rd_win && !rd_arm) begin
      for (int i = 0; i < NPOS; i++)
        if (addr_q == POS_BASE + 8'(i)) lo_q[i] <= bus_in;
      if (addr_q == MSB_ADDR) msb_q <= bus_in[NPOS-1:0];
      for (int j = 0; j < NCFG; j++)
        if (addr_q == CFG_BASE + 8'(j)) cfg_q[j] <= bus_in;
    end

  always_comb
    case (addr_q)
      RD_CMD:  rd_data = {5'b0, fld_id, fld_len[9:8]};
      LEN_LO:  rd_data = fld_len[7:0];
      default: rd_data = 8'h00;
    endcase

  assign bus_oe  = rd_win & ~wrd_sh[1];
  assign bus_out = bus_oe ? rd_data : 8'h00;

  for (genvar i = 0; i < NPOS; i++) begin : g_pos
    assign pos_flat[9*i +: 9] = {msb_q[i], lo_q[i]};
  end
  for (genvar j = 0; j < NCFG; j++) begin : g_cfg
    assign cfg_flat[8*j +: 8] = cfg_q[j];
  end
endmodule

// File: rtl/hostbus_port_chk.sv
module hostbus_port_chk #(
  parameter int PW = 72,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale_fall,
  input logic          wrd_fall,
  input logic          rd_arm,
  input logic          rd_win,
  input logic          bus_oe,
  input logic [PW-1:0] pos_flat,
  input logic [CW-1:0] cfg_flat
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pos_flat == '0 && cfg_flat == '0 && !bus_oe));

  assert_no_write_without_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wrd_fall |=> ($stable(pos_flat) && $stable(cfg_flat)));

  assert_arm_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_arm && !ale_fall) |=> rd_arm);

  assert_arm_opens_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_arm && ale_fall) |=> (rd_win && !rd_arm));

  assert_oe_needs_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(rd_win));

  assert_idle_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_win && !rd_arm) |-> !bus_oe);

  assert_window_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_win |=> ($stable(pos_flat) && $stable(cfg_flat)));
endmodule

bind hostbus_port hostbus_port_chk #(.PW(NPOS*9), .CW(NCFG*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale_fall(ale_fall), .wrd_fall(wrd_fall),
  .rd_arm(rd_arm), .rd_win(rd_win), .bus_oe(bus_oe),
  .pos_flat(pos_flat), .cfg_flat(cfg_flat)
);

// File: tb/hostbus_port_bench.sv
module hostbus_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ale = 1'b0, wrd = 1'b1, fld_id = 1'b0;
  logic [7:0] bus_in = '0;
  logic [9:0] fld_len = '0;
  logic [7:0] bus_out;
  logic bus_oe;
  logic [71:0] pos_flat;
  logic [31:0] cfg_flat;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [7:0] e_lo [8];
  logic [7:0] e_msb;
  logic [7:0] e_cfg [4];

  always #5 clk = ~clk;

  hostbus_port u_hostbus_port (
    .clk(clk), .rst_n(rst_n), .ale(ale), .wrd(wrd), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .fld_len(fld_len), .fld_id(fld_id),
    .pos_flat(pos_flat), .cfg_flat(cfg_flat)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [71:0] exp_pos();
    logic [71:0] v;
    for (int i = 0; i < 8; i++) v[9*i +: 9] = {e_msb[i], e_lo[i]};
    return v;
  endfunction

  function automatic logic [31:0] exp_cfg();
    return {e_cfg[3], e_cfg[2], e_cfg[1], e_cfg[0]};
  endfunction

  task automatic chk_regs(string req);
    chk(req, 128'(pos_flat), 128'(exp_pos()));
    chk(req, 128'(cfg_flat), 128'(exp_cfg()));
  endtask

  task automatic addr_phase(logic [7:0] a);
    @(negedge clk); bus_in = a; ale = 1'b1;
    repeat (2) @(negedge clk);
    ale = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic data_phase(logic [7:0] d);
    @(negedge clk); bus_in = d; wrd = 1'b0;
    repeat (4) @(negedge clk);
    wrd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_write(logic [7:0] a, logic [7:0] d);
    addr_phase(a);
    data_phase(d);
  endtask

  task automatic host_read(logic [7:0] a, logic [7:0] exp, string req);
    addr_phase(8'h80);
    data_phase(8'h5A);
    chk({req, " arm cycle writes nothing"}, 128'(pos_flat), 128'(exp_pos()));
    addr_phase(a);
    chk({req, " no drive before strobe"}, 128'(bus_oe), 128'(1'b0));
    @(negedge clk); bus_in = 8'hC3; wrd = 1'b0;
    repeat (4) @(negedge clk);
    chk({req, " oe during read"}, 128'(bus_oe), 128'(1'b1));
    chk({req, " read data"}, 128'(bus_out), 128'(exp));
    wrd = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 oe released", 128'(bus_oe), 128'(1'b0));
    chk_regs("R10 no write in read cycle");
  endtask

  task automatic t_reset;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_regs("R1 reset clear");
    chk("R1 input mode", 128'(bus_oe), 128'(1'b0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_regs("R1 after release");
  endtask

  task automatic t_low_bytes;
    for (int i = 0; i < 8; i++) begin
      host_write(8'h40 + 8'(i), 8'(8'h11 * (i + 1)));
      e_lo[i] = 8'(8'h11 * (i + 1));
    end
    chk_regs("R2 low bytes");
  endtask

  task automatic t_collector;
    host_write(8'h48, 8'hA5); e_msb = 8'hA5;
    chk_regs("R3 collector");
    host_write(8'h43, 8'h00); e_lo[3] = 8'h00;
    chk_regs("R3 low keeps msb");
    host_write(8'h48, 8'h3C); e_msb = 8'h3C;
    chk_regs("R3 msb keeps low");
  endtask

  task automatic t_cfg;
    host_write(8'h49, 8'hDE); e_cfg[0] = 8'hDE;
    host_write(8'h4C, 8'h77); e_cfg[3] = 8'h77;
    host_write(8'h4A, 8'h01); e_cfg[1] = 8'h01;
    chk_regs("R4 config bytes");
  endtask

  task automatic t_unmapped;
    host_write(8'h20, 8'hFF);
    chk_regs("R5 write 0x20");
    host_write(8'h4D, 8'hFF);
    chk_regs("R5 write 0x4D");
    host_write(8'h3F, 8'hFF);
    chk_regs("R5 write 0x3F");
  endtask

  task automatic t_reads;
    fld_len = 10'h2B7; fld_id = 1'b1;
    host_read(8'h80, 8'h06, "R8 status");
    fld_len = 10'h1C4; fld_id = 1'b0;
    host_read(8'h80, 8'h01, "R8 status b");
    host_read(8'h81, 8'hC4, "R8 length low");
    host_read(8'h49, 8'h00, "R9 unmapped read");
  endtask

  task automatic t_one_shot;
    host_read(8'h81, 8'hC4, "R6 read");
    addr_phase(8'h81);
    @(negedge clk); bus_in = 8'h99; wrd = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 no drive after window", 128'(bus_oe), 128'(1'b0));
    wrd = 1'b1;
    repeat (4) @(negedge clk);
    host_write(8'h4B, 8'h42); e_cfg[2] = 8'h42;
    chk_regs("R10 normal write after read");
  endtask

  task automatic t_latency;
    addr_phase(8'h47);
    @(negedge clk); bus_in = 8'hE7; wrd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_regs("R11 not yet after k+1");
    @(negedge clk);
    e_lo[7] = 8'hE7;
    chk_regs("R11 written after k+2");
    wrd = 1'b1;
    repeat (4) @(negedge clk);
    addr_phase(8'h80);
    data_phase(8'h00);
    addr_phase(8'h81);
    @(negedge clk); wrd = 1'b0;
    @(negedge clk);
    chk("R11 oe not after k", 128'(bus_oe), 128'(1'b0));
    @(negedge clk);
    chk("R11 oe after k+1", 128'(bus_oe), 128'(1'b1));
    wrd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) e_lo[i] = '0;
    for (int j = 0; j < 4; j++) e_cfg[j] = '0;
    e_msb = '0;
    t_reset();
    t_low_bytes();
    t_collector();
    t_cfg();
    t_unmapped();
    t_reads();
    t_one_shot();
    t_latency();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      vectors++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule